// File: doc/BRIEF.md
# Monochrome CCD Camera Video Sync Generator

This block derives the horizontal and vertical reference timing for a monochrome CCD camera. The input clock is halved to form a master clock, and one video line spans a fixed number of master clocks. From a horizontal position counter and a field-relative half-line counter it produces horizontal drive, vertical drive, composite sync, composite blanking and an odd/even field flag. All outputs are registered.

Two television standards are selected by one input: standard A (525-line frame, 20-line vertical blanking, 9-line vertical sync region) and standard B (625-line frame, 25-line vertical blanking, 7.5-line region). Each has its own horizontal blanking width. In interlace mode a field is half a frame, so the second field starts at mid-line. In non-interlace mode every field starts at a line boundary and has a selectable length of (frame-1)/2 lines or one line more. An external sync block can pulse a vertical reset request that carries a line number. That number is loaded into the vertical position at the next line boundary.

Top module: `ccd_sync_gen`

## Requirements
- R1: While reset is applied, and until two clock edges after its release, all active-low outputs (`hd_no`, `vd_no`, `sync_no`, `blk_no`) are high and `fld_o` is high.
- R2: The master clock advances on every second clock. A line lasts H_TOTAL master clocks. `hd_no` is low for the first H_SYNC master clocks of every line.
- R3: `blk_no` is low during the first H_BLK_A master clocks of each line when `std_b_i`=0, and during the first H_BLK_B when `std_b_i`=1.
- R4: `blk_no` is low throughout the first 2*V_BLK_A (standard A) or 2*V_BLK_B (standard B) half-lines of every field.
- R5: The vertical sync region of VSYNC_HALF_A or VSYNC_HALF_B half-lines at the start of a field is split into three equal thirds. `vd_no` is low for exactly the middle third.
- R6: In the first and last third of that region, `sync_no` goes low for H_EQ master clocks at the start of every half-line (equalizing pulses).
- R7: In the middle third, `sync_no` is low for H_TOTAL/2-H_SYNC master clocks from each half-line start (serrated sync). Outside the region, `sync_no` follows `hd_no`.
- R8: In interlace mode (`nonint_i`=0), a field is V_LINES half-lines long and `fld_o` toggles at every field start. The field with `fld_o`=1 (odd) starts at a line start, and the even field starts at mid-line.
- R9: In non-interlace mode, a field is 2*((V_LINES-1)/2 + `long_field_i`) half-lines long, and each new field sets `fld_o` high.
- R10: A one-clock pulse on `vrst_i` captures `vrst_line_i`. At the next line boundary, the field position jumps to the start of that line and `fld_o` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock, twice the master clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| std_b_i | input | 1 | 0: standard A (525 lines), 1: standard B (625 lines) |
| nonint_i | input | 1 | 1: non-interlace operation |
| long_field_i | input | 1 | Non-interlace field length select: 1 adds one line |
| vrst_i | input | 1 | Vertical reset request pulse |
| vrst_line_i | input | LW | Line number loaded by the vertical reset |
| hd_no | output | 1 | Horizontal drive, active low |
| vd_no | output | 1 | Vertical drive, active low |
| sync_no | output | 1 | Composite sync, active low |
| blk_no | output | 1 | Composite blanking, active low |
| fld_o | output | 1 | Field flag, 1 = odd field |

## Verification
The bench builds the block with a 40-master-clock line, 25-line and 31-line frames, blanking of 5 and 6 lines, and sync regions of 6 and 9 half-lines. At these sizes a whole frame fits in about 2,000 clocks, so the run can reach field wraps, the mid-line start of the even field, both non-interlace lengths and many vertical resets at random points for both standards. The horizontal and vertical widths keep the same relationships as the full-size values: equalizing pulses narrower than sync, sync narrower than blanking, and the vertical sync region inside vertical blanking.

// File: rtl/ccd_sync_pkg.sv
package ccd_sync_pkg;

  // Registered video outputs, active-low strobes plus field flag
  typedef struct packed {
    logic hd_n;
    logic vd_n;
    logic sync_n;
    logic blk_n;
    logic fld;
  } vid_out_t;

  localparam vid_out_t VID_IDLE = '{hd_n: 1'b1, vd_n: 1'b1, sync_n: 1'b1,
                                    blk_n: 1'b1, fld: 1'b1};

endpackage

// File: rtl/vsg_mck_div.sv
module vsg_mck_div (
  input  logic clk_i,
  input  logic rst_ni,
  output logic mck_en_o
);

  logic ph_q, ph_d;

  always_comb ph_d = ~ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ph_d;
  end

  assign mck_en_o = ph_q;

  // R2: master-clock enable alternates every clock
  a_r2_mck_alternate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mck_en_o |=> !mck_en_o);

endmodule

// File: rtl/vsg_hcount.sv
module vsg_hcount #(
  parameter int H_TOTAL = 606,
  localparam int HW = $clog2(H_TOTAL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mck_en_i,
  output logic [HW-1:0] hcnt_o,
  output logic          line_end_o,
  output logic          half_end_o
);

  localparam logic [HW-1:0] LAST     = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] MID_LAST = HW'(H_TOTAL / 2 - 1);

  logic [HW-1:0] hcnt_q, hcnt_d;

  always_comb begin
    hcnt_d = hcnt_q;
    if (mck_en_i) hcnt_d = (hcnt_q == LAST) ? '0 : hcnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hcnt_q <= '0;
    else         hcnt_q <= hcnt_d;
  end

  assign hcnt_o     = hcnt_q;
  assign line_end_o = mck_en_i && (hcnt_q == LAST);
  assign half_end_o = mck_en_i && ((hcnt_q == LAST) || (hcnt_q == MID_LAST));

  // R2: position stays inside the line
  a_r2_hcnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcnt_q <= LAST);
  // R2: position moves only on master-clock edges
  a_r2_hcnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mck_en_i |=> $stable(hcnt_q));

endmodule

// File: rtl/vsg_vcount.sv
module vsg_vcount #(
  parameter int V_LINES_A = 525,
  parameter int V_LINES_B = 625,
  localparam int LW = $clog2(V_LINES_B),
  localparam int VW = LW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_end_i,
  input  logic          half_end_i,
  input  logic          std_b_i,
  input  logic          nonint_i,
  input  logic          long_i,
  input  logic          vrst_i,
  input  logic [LW-1:0] vrst_line_i,
  output logic [VW-1:0] hl_o,
  output logic          fld_o
);

  localparam logic [VW-1:0] LIM_IA  = VW'(V_LINES_A);
  localparam logic [VW-1:0] LIM_IB  = VW'(V_LINES_B);
  localparam logic [VW-1:0] LIM_NA0 = VW'(2 * ((V_LINES_A - 1) / 2));
  localparam logic [VW-1:0] LIM_NB0 = VW'(2 * ((V_LINES_B - 1) / 2));
  localparam logic [VW-1:0] TWO     = VW'(2);

  logic [VW-1:0] hl_q, hl_d, lim;
  logic          fld_q, fld_d;
  logic          pend_q, pend_d;
  logic [LW-1:0] line_q, line_d;
  logic          load, wrap;

  // Field length in half-lines for the selected standard and scan mode
  always_comb begin
    if (!nonint_i) lim = std_b_i ? LIM_IB : LIM_IA;
    else           lim = (std_b_i ? LIM_NB0 : LIM_NA0) + (long_i ? TWO : '0);
  end

  always_comb begin
    load   = line_end_i && pend_q;
    wrap   = half_end_i && (hl_q >= lim - 1'b1);
    hl_d   = hl_q;
    fld_d  = fld_q;
    if (load) begin
      hl_d  = {line_q, 1'b0};
      fld_d = 1'b1;
    end else if (wrap) begin
      hl_d  = '0;
      fld_d = nonint_i ? 1'b1 : ~fld_q;
    end else if (half_end_i) begin
      hl_d  = hl_q + 1'b1;
    end
    pend_d = vrst_i | (pend_q & ~line_end_i);
    line_d = vrst_i ? vrst_line_i : line_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hl_q   <= '0;
      fld_q  <= 1'b1;
      pend_q <= 1'b0;
      line_q <= '0;
    end else begin
      hl_q   <= hl_d;
      fld_q  <= fld_d;
      pend_q <= pend_d;
      line_q <= line_d;
    end
  end

  assign hl_o  = hl_q;
  assign fld_o = fld_q;

  // R10: a pending request lands on the requested line in the odd field
  a_r10_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_end_i && pend_q) |=> (hl_q == {$past(line_q), 1'b0}) && fld_q);
  // R9: non-interlace never leaves the odd field once in it
  a_r9_ni_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nonint_i && fld_q) |=> fld_q);
  // R8: interlace field wrap flips the field flag
  a_r8_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nonint_i && half_end_i && !(line_end_i && pend_q) && (hl_q >= lim - 1'b1))
      |=> (fld_q != $past(fld_q)) && (hl_q == '0));

endmodule

// File: rtl/vsg_decode.sv
module vsg_decode
  import ccd_sync_pkg::*;
#(
  parameter int H_TOTAL      = 606,
  parameter int H_SYNC       = 45,
  parameter int H_EQ         = 22,
  parameter int H_BLK_A      = 104,
  parameter int H_BLK_B      = 114,
  parameter int V_BLK_A      = 20,
  parameter int V_BLK_B      = 25,
  parameter int VSYNC_HALF_A = 18,
  parameter int VSYNC_HALF_B = 15,
  parameter int VW           = 11,
  localparam int HW = $clog2(H_TOTAL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [HW-1:0] hcnt_i,
  input  logic [VW-1:0] hl_i,
  input  logic          fld_i,
  input  logic          std_b_i,
  output vid_out_t      out_o
);

  localparam logic [HW-1:0] HALF = HW'(H_TOTAL / 2);
  localparam logic [HW-1:0] HS   = HW'(H_SYNC);
  localparam logic [HW-1:0] EQW  = HW'(H_EQ);
  localparam logic [HW-1:0] SERW = HW'(H_TOTAL / 2 - H_SYNC);
  localparam logic [HW-1:0] HBA  = HW'(H_BLK_A);
  localparam logic [HW-1:0] HBB  = HW'(H_BLK_B);
  localparam logic [VW-1:0] PA   = VW'(VSYNC_HALF_A / 3);
  localparam logic [VW-1:0] PB   = VW'(VSYNC_HALF_B / 3);
  localparam logic [VW-1:0] VBA  = VW'(2 * V_BLK_A);
  localparam logic [VW-1:0] VBB  = VW'(2 * V_BLK_B);

  logic [HW-1:0] hp, hblk;
  logic [VW-1:0] p1, p2, p3, vblk;
  logic          in_eq, in_ser;
  vid_out_t      nxt, out_q;

  always_comb begin
    hp     = (hcnt_i >= HALF) ? hcnt_i - HALF : hcnt_i;
    p1     = std_b_i ? PB : PA;
    p2     = p1 + p1;
    p3     = p2 + p1;
    hblk   = std_b_i ? HBB : HBA;
    vblk   = std_b_i ? VBB : VBA;
    in_ser = (hl_i >= p1) && (hl_i < p2);
    in_eq  = (hl_i < p1) || ((hl_i >= p2) && (hl_i < p3));
    nxt.hd_n = !(hcnt_i < HS);
    nxt.vd_n = !in_ser;
    if (in_eq)       nxt.sync_n = !(hp < EQW);
    else if (in_ser) nxt.sync_n = !(hp < SERW);
    else             nxt.sync_n = !(hcnt_i < HS);
    nxt.blk_n = !((hcnt_i < hblk) || (hl_i < vblk));
    nxt.fld   = fld_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= VID_IDLE;
    else         out_q <= nxt;
  end

  assign out_o = out_q;

  // R3: horizontal drive lies inside horizontal blanking
  a_r3_hd_in_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_q.hd_n |-> !out_q.blk_n);
  // R5: vertical drive lies inside vertical blanking
  a_r5_vd_in_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_q.vd_n |-> !out_q.blk_n);

endmodule

// File: rtl/ccd_sync_gen.sv
module ccd_sync_gen
  import ccd_sync_pkg::*;
#(
  parameter int H_TOTAL      = 606,
  parameter int H_SYNC       = 45,
  parameter int H_EQ         = 22,
  parameter int H_BLK_A      = 104,
  parameter int H_BLK_B      = 114,
  parameter int V_LINES_A    = 525,
  parameter int V_LINES_B    = 625,
  parameter int V_BLK_A      = 20,
  parameter int V_BLK_B      = 25,
  parameter int VSYNC_HALF_A = 18,
  parameter int VSYNC_HALF_B = 15,
  localparam int HW = $clog2(H_TOTAL),
  localparam int LW = $clog2(V_LINES_B),
  localparam int VW = LW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          std_b_i,
  input  logic          nonint_i,
  input  logic          long_field_i,
  input  logic          vrst_i,
  input  logic [LW-1:0] vrst_line_i,
  output logic          hd_no,
  output logic          vd_no,
  output logic          sync_no,
  output logic          blk_no,
  output logic          fld_o
);

  logic          rst_s1, rst_s2;
  logic          mck_en, line_end, half_end, fld;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] hl;
  vid_out_t      vo;

  // Reset asserts at once, releases after two clock edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  vsg_mck_div u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_s2),
    .mck_en_o (mck_en)
  );

  vsg_hcount #(.H_TOTAL(H_TOTAL)) u_hcnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_s2),
    .mck_en_i   (mck_en),
    .hcnt_o     (hcnt),
    .line_end_o (line_end),
    .half_end_o (half_end)
  );

  vsg_vcount #(.V_LINES_A(V_LINES_A), .V_LINES_B(V_LINES_B)) u_vcnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_s2),
    .line_end_i  (line_end),
    .half_end_i  (half_end),
    .std_b_i     (std_b_i),
    .nonint_i    (nonint_i),
    .long_i      (long_field_i),
    .vrst_i      (vrst_i),
    .vrst_line_i (vrst_line_i),
    .hl_o        (hl),
    .fld_o       (fld)
  );

  vsg_decode #(
    .H_TOTAL(H_TOTAL), .H_SYNC(H_SYNC), .H_EQ(H_EQ),
    .H_BLK_A(H_BLK_A), .H_BLK_B(H_BLK_B),
    .V_BLK_A(V_BLK_A), .V_BLK_B(V_BLK_B),
    .VSYNC_HALF_A(VSYNC_HALF_A), .VSYNC_HALF_B(VSYNC_HALF_B), .VW(VW)
  ) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_s2),
    .hcnt_i  (hcnt),
    .hl_i    (hl),
    .fld_i   (fld),
    .std_b_i (std_b_i),
    .out_o   (vo)
  );

  assign hd_no   = vo.hd_n;
  assign vd_no   = vo.vd_n;
  assign sync_no = vo.sync_n;
  assign blk_no  = vo.blk_n;
  assign fld_o   = vo.fld;

  // R1: outputs stay idle while the internal reset is held
  a_r1_idle_in_reset: assert property (@(posedge clk_i)
    (rst_ni && !rst_s1) |=> (hd_no && vd_no && sync_no && blk_no && fld_o));

endmodule

// File: tb/ccd_sync_gen_tb.sv
module ccd_sync_gen_tb;

  localparam int H_TOTAL = 40, H_SYNC = 6, H_EQ = 3;
  localparam int H_BLK_A = 10, H_BLK_B = 12;
  localparam int V_LINES_A = 25, V_LINES_B = 31;
  localparam int V_BLK_A = 5, V_BLK_B = 6;
  localparam int VSYNC_HALF_A = 6, VSYNC_HALF_B = 9;
  localparam int LW = $clog2(V_LINES_B);

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic std_b = 1'b0, nonint = 1'b0, long_f = 1'b0, vrst = 1'b0;
  logic [LW-1:0] vline = '0;
  logic hd_n, vd_n, sync_n, blk_n, fld;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ccd_sync_gen #(
    .H_TOTAL(H_TOTAL), .H_SYNC(H_SYNC), .H_EQ(H_EQ),
    .H_BLK_A(H_BLK_A), .H_BLK_B(H_BLK_B),
    .V_LINES_A(V_LINES_A), .V_LINES_B(V_LINES_B),
    .V_BLK_A(V_BLK_A), .V_BLK_B(V_BLK_B),
    .VSYNC_HALF_A(VSYNC_HALF_A), .VSYNC_HALF_B(VSYNC_HALF_B)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .std_b_i(std_b), .nonint_i(nonint),
    .long_field_i(long_f), .vrst_i(vrst), .vrst_line_i(vline),
    .hd_no(hd_n), .vd_no(vd_n), .sync_no(sync_n), .blk_no(blk_n), .fld_o(fld)
  );

  // Reference state, built from the requirements
  int m_hc = 0, m_hl = 0, m_lq = 0;
  bit m_ph = 0, m_fld = 1, m_pend = 0, s1 = 0, s2 = 0;
  logic [4:0] exp_o = 5'b11111;  // {hd,vd,sync,blk,fld}

  function automatic logic [4:0] expect_out(int hc, int hl, bit f, bit sb);
    int hp, p, hb, vb;
    bit eq, ser, hd_l, sy_l, bl_l;
    hp  = (hc >= H_TOTAL / 2) ? hc - H_TOTAL / 2 : hc;
    p   = (sb ? VSYNC_HALF_B : VSYNC_HALF_A) / 3;
    hb  = sb ? H_BLK_B : H_BLK_A;
    vb  = 2 * (sb ? V_BLK_B : V_BLK_A);
    ser = (hl >= p) && (hl < 2 * p);
    eq  = (hl < p) || ((hl >= 2 * p) && (hl < 3 * p));
    hd_l = hc < H_SYNC;
    if (eq)       sy_l = hp < H_EQ;
    else if (ser) sy_l = hp < H_TOTAL / 2 - H_SYNC;
    else          sy_l = hd_l;
    bl_l = (hc < hb) || (hl < vb);
    return {!hd_l, !ser, !sy_l, !bl_l, f};
  endfunction

  function automatic int field_len(bit sb, bit ni, bit lg);
    int vl;
    vl = sb ? V_LINES_B : V_LINES_A;
    return ni ? 2 * ((vl - 1) / 2 + int'(lg)) : vl;
  endfunction

  task automatic check_bit(logic act, logic exp, string req, string name);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, name, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      string rq_fld;
      bit le, he;
      int lim;
      if (!s2) begin
        check_bit(hd_n, exp_o[4], "R1", "hd_no");
        check_bit(vd_n, exp_o[3], "R1", "vd_no");
        check_bit(sync_n, exp_o[2], "R1", "sync_no");
        check_bit(blk_n, exp_o[1], "R1", "blk_no");
        check_bit(fld, exp_o[0], "R1", "fld_o");
      end else begin
        rq_fld = nonint ? "R9 R10" : "R8 R10";
        check_bit(hd_n, exp_o[4], "R2", "hd_no");
        check_bit(vd_n, exp_o[3], "R5", "vd_no");
        check_bit(sync_n, exp_o[2], "R6 R7", "sync_no");
        check_bit(blk_n, exp_o[1], "R3 R4", "blk_no");
        check_bit(fld, exp_o[0], rq_fld, "fld_o");
      end
      // advance the reference to the next rising edge
      if (!rst_n) begin
        s1 = 0; s2 = 0; exp_o = 5'b11111;
        m_hc = 0; m_hl = 0; m_fld = 1; m_ph = 0; m_pend = 0; m_lq = 0;
      end else begin
        if (s2) begin
          exp_o = expect_out(m_hc, m_hl, m_fld, std_b);
          le  = m_ph && (m_hc == H_TOTAL - 1);
          he  = m_ph && ((m_hc == H_TOTAL - 1) || (m_hc == H_TOTAL / 2 - 1));
          lim = field_len(std_b, nonint, long_f);
          if (le && m_pend) begin
            m_hl = 2 * m_lq; m_fld = 1;
          end else if (he) begin
            if (m_hl >= lim - 1) begin
              m_hl = 0; m_fld = nonint ? 1'b1 : !m_fld;
            end else m_hl++;
          end
          m_pend = vrst || (m_pend && !le);
          if (vrst) m_lq = int'(vline);
          if (m_ph) m_hc = (m_hc == H_TOTAL - 1) ? 0 : m_hc + 1;
          m_ph = !m_ph;
        end else exp_o = 5'b11111;
        s2 = s1; s1 = 1;
      end
    end
  end

  task automatic run_seg(bit sb, bit ni, bit lg, int ncyc, int rate);
    @(posedge clk); #2;
    std_b = sb; nonint = ni; long_f = lg;
    for (int i = 0; i < ncyc; i++) begin
      @(posedge clk); #2;
      vrst = 1'b0;
      if (rate != 0 && ($urandom % rate) == 0) begin
        vrst  = 1'b1;
        vline = LW'($urandom % (field_len(sb, ni, lg) / 2));
      end
    end
    @(posedge clk); #2;
    vrst = 1'b0;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd5412);
    #1 rst_n = 1'b0;
    repeat (6) @(posedge clk);
    #2 rst_n = 1'b1;
    // directed: both standards, interlace, two frames each (R8, R2-R7)
    run_seg(1'b0, 1'b0, 1'b0, 4200, 0);
    run_seg(1'b1, 1'b0, 1'b0, 5200, 0);
    // directed: non-interlace short and long fields (R9)
    run_seg(1'b0, 1'b1, 1'b0, 4200, 0);
    run_seg(1'b0, 1'b1, 1'b1, 4400, 0);
    run_seg(1'b1, 1'b1, 1'b0, 5000, 0);
    run_seg(1'b1, 1'b1, 1'b1, 5200, 0);
    // directed V-reset in interlace even field region (R10)
    run_seg(1'b0, 1'b0, 1'b0, 1500, 0);
    @(posedge clk); #2 vrst = 1'b1; vline = LW'(3);
    @(posedge clk); #2 vrst = 1'b0;
    run_seg(1'b0, 1'b0, 1'b0, 2500, 0);
    // random modes with random V-resets
    for (int k = 0; k < 12; k++)
      run_seg(1'($urandom), 1'($urandom), 1'($urandom), 2000 + ($urandom % 1500), 700);
    repeat (4) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule